// File: doc/BRIEF.md
# 4x4 Integer Inverse Transform with Reconstruction

This block turns one 4x4 block of signed 16-bit residual coefficients and the matching sixteen 8-bit predicted pixels into sixteen reconstructed 8-bit pixels. It uses the exact integer inverse transform of the video standard, not a cosine approximation. A one-dimensional butterfly runs over every row and then over every column, with all half weights made by arithmetic shifts. The two-pass result is rounded, scaled down by 64 and added to the prediction. The sum is then clamped to the 8-bit range.

A valid/ready handshake carries one whole block per transfer on each side. The pipeline has three register stages and moves one block per clock whenever the output is not stalled. The first stage is the coefficient store. That store is zeroed as soon as its block moves on and no new block replaces it, so the store is never left holding a stale block.

Top module: `itx4_recon`

## Requirements
- R1: Coefficient k sits at `in_coef[16k+15:16k]` and belongs to row k mod 4, column k div 4 (column-major). Pixel p of `in_pred` and `out_pix` sits at bits `[8p+7:8p]` and belongs to row p div 4, column p mod 4 (row-major).
- R2: Each 1-D pass maps a0..a3 to e+h, f+g, f-g, e-h, where e=a0+a2, f=a0-a2, g=(a1>>>1)-a3 and h=a1+(a3>>>1). The pass is applied to all four rows first and then to all four columns of that result.
- R3: Every half weight is an arithmetic shift right by one, so odd negative values round toward minus infinity.
- R4: Each residual is (t+32)>>>6, where t is the two-pass result and the shift is arithmetic, so negative residuals floor.
- R5: Each output pixel is pred plus the residual, clamped to 0..255.
- R6: Any mix of full-range 16-bit coefficients, including all -32768 and all 32767, reconstructs without internal overflow.
- R7: The coefficient store reads zero whenever it holds no block. A block that follows a large block carries no residue from it.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` stays unchanged.
- R9: A block accepted at a clock edge is presented on `out_pix` after the third following falling edge, that is, three register stages later. With `out_ready` high, one block is accepted and one delivered per cycle, and at most three blocks are in flight.
- R10: During reset `out_valid` is low and `in_ready` is high. `in_ready` is high whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Block can be taken this cycle |
| in_coef | input | 256 | Sixteen signed coefficients, column-major |
| in_pred | input | 128 | Sixteen predicted pixels, row-major |
| out_valid | output | 1 | Reconstructed block available |
| out_ready | input | 1 | Consumer takes the block |
| out_pix | output | 128 | Sixteen reconstructed pixels, row-major |

## Verification
A wrong butterfly sign, a lost shift or a swapped coefficient order shows as wrong pixels three cycles after the block enters. Almost every random block exposes such a fault, and a row-major reading fails on the first block with unequal off-diagonal coefficients. A store that is not cleared cannot be seen directly at the ports. It is caught by the checker in the first idle cycle after a transfer, and the zero block that follows a large one guards the same fault from the pixel side. Stall faults show within one cycle, as output data changing while it is held, or as a block delivered at the wrong time.

// File: rtl/itx4_pkg.sv
package itx4_pkg;
  parameter int COEF_W  = 16;
  parameter int PIX_W   = 8;
  parameter int DIM     = 4;
  parameter int NCOEF   = DIM * DIM;
  parameter int ACC_W   = COEF_W + 5;   // wide enough for both passes
  parameter int SHIFT   = 6;
  parameter int ROUND   = 1 << (SHIFT - 1);
  parameter int PIX_MAX = (1 << PIX_W) - 1;
  parameter int LATENCY = 3;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef acc_t [DIM-1:0] quad_t;
  typedef logic [PIX_W-1:0] pix_t;

  // one-dimensional integer butterfly, half weights as shifts
  function automatic quad_t bfly(quad_t a);
    acc_t a0, a1, a2, a3, e, f, g, h;
    quad_t y;
    a0 = a[0]; a1 = a[1]; a2 = a[2]; a3 = a[3];
    e = a0 + a2;
    f = a0 - a2;
    g = (a1 >>> 1) - a3;
    h = a1 + (a3 >>> 1);
    y[0] = e + h;
    y[1] = f + g;
    y[2] = f - g;
    y[3] = e - h;
    return y;
  endfunction

  // round, scale, add prediction and clamp
  function automatic pix_t recon(acc_t t, pix_t p);
    acc_t s, v;
    s = (t + acc_t'(ROUND)) >>> SHIFT;
    v = s + acc_t'({1'b0, p});
    if (v < 0) return '0;
    else if (v > acc_t'(PIX_MAX)) return pix_t'(PIX_MAX);
    else return v[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/itx4_rowpass.sv
module itx4_rowpass
  import itx4_pkg::*;
(
  input  logic [NCOEF*COEF_W-1:0] coef_flat,
  output logic [NCOEF*ACC_W-1:0]  row_flat
);
  // coefficient k -> row k%DIM, column k/DIM; output row-major
  for (genvar r = 0; r < DIM; r++) begin : g_row
    quad_t a, y;
    always_comb begin
      for (int j = 0; j < DIM; j++)
        a[j] = acc_t'($signed(coef_flat[(DIM*j + r)*COEF_W +: COEF_W]));
      y = bfly(a);
    end
    for (genvar j = 0; j < DIM; j++) begin : g_out
      assign row_flat[(DIM*r + j)*ACC_W +: ACC_W] = y[j];
    end
  end
endmodule

// File: rtl/itx4_colrecon.sv
module itx4_colrecon
  import itx4_pkg::*;
(
  input  logic [NCOEF*ACC_W-1:0] row_flat,
  input  logic [NCOEF*PIX_W-1:0] pred_flat,
  output logic [NCOEF*PIX_W-1:0] pix_flat
);
  for (genvar c = 0; c < DIM; c++) begin : g_col
    quad_t a, t;
    always_comb begin
      for (int i = 0; i < DIM; i++)
        a[i] = acc_t'(row_flat[(DIM*i + c)*ACC_W +: ACC_W]);
      t = bfly(a);
    end
    for (genvar i = 0; i < DIM; i++) begin : g_pix
      assign pix_flat[(DIM*i + c)*PIX_W +: PIX_W] =
        recon(t[i], pred_flat[(DIM*i + c)*PIX_W +: PIX_W]);
    end
  end
endmodule

// File: rtl/itx4_recon.sv
module itx4_recon
  import itx4_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NCOEF*COEF_W-1:0]  in_coef,
  input  logic [NCOEF*PIX_W-1:0]   in_pred,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NCOEF*PIX_W-1:0]   out_pix
);
  // whole pipeline moves together; LATENCY register stages
  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // stage 1: coefficient store, zeroed when left empty
  logic                    s1_valid;
  logic [NCOEF*COEF_W-1:0] s1_coef;
  logic [NCOEF*PIX_W-1:0]  s1_pred;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_coef  <= '0;
      s1_pred  <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      s1_coef  <= in_valid ? in_coef : '0;
      s1_pred  <= in_valid ? in_pred : '0;
    end
  end

  logic [NCOEF*ACC_W-1:0] row_w;
  itx4_rowpass u_row (.coef_flat(s1_coef), .row_flat(row_w));

  // stage 2: row-pass results
  logic                   s2_valid;
  logic [NCOEF*ACC_W-1:0] s2_row;
  logic [NCOEF*PIX_W-1:0] s2_pred;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_row   <= '0;
      s2_pred  <= '0;
    end else if (advance) begin
      s2_valid <= s1_valid;
      s2_row   <= row_w;
      s2_pred  <= s1_pred;
    end
  end

  logic [NCOEF*PIX_W-1:0] pix_w;
  itx4_colrecon u_col (.row_flat(s2_row), .pred_flat(s2_pred), .pix_flat(pix_w));

  // stage 3: output register
  logic                   o_valid;
  logic [NCOEF*PIX_W-1:0] o_pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_pix   <= '0;
    end else if (advance) begin
      o_valid <= s2_valid;
      o_pix   <= pix_w;
    end
  end

  assign out_valid = o_valid;
  assign out_pix   = o_pix;
endmodule

// File: rtl/itx4_recon_chk.sv
module itx4_recon_chk
  import itx4_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [NCOEF*PIX_W-1:0]  out_pix,
  input logic                    s1_valid,
  input logic [NCOEF*COEF_W-1:0] s1_coef
);
  logic [2:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R7
  store_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |-> (s1_coef == '0));

  // R9
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'(LATENCY));

  // R10
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind itx4_recon itx4_recon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
  .s1_valid(s1_valid), .s1_coef(s1_coef)
);

// File: tb/itx4_recon_test.sv
module itx4_recon_test;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_coef = '0;
  logic [127:0] in_pred = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_pix;

  itx4_recon uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic [127:0] pix;
    int           cyc;
    bit           timed;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) cyc++;

  always @(negedge clk) out_ready <= stall_mode ? 1'($urandom % 2) : 1'b1;

  // reference: floor halves and floor division, written on ints
  function automatic int half_f(int v);
    return (v < 0 && (v % 2) != 0) ? (v - 1) / 2 : v / 2;
  endfunction
  function automatic int floordiv(int v, int d);
    return (v >= 0) ? v / d : -((-v + d - 1) / d);
  endfunction

  function automatic logic [127:0] model(logic [255:0] c, logic [127:0] p);
    int x[4][4];
    int m[4][4];
    logic [127:0] res;
    for (int k = 0; k < 16; k++) x[k % 4][k / 4] = int'($signed(c[16*k +: 16]));
    for (int r = 0; r < 4; r++) begin
      m[r][0] = x[r][0] + x[r][2] + x[r][1] + half_f(x[r][3]);
      m[r][1] = x[r][0] - x[r][2] + half_f(x[r][1]) - x[r][3];
      m[r][2] = x[r][0] - x[r][2] - half_f(x[r][1]) + x[r][3];
      m[r][3] = x[r][0] + x[r][2] - x[r][1] - half_f(x[r][3]);
    end
    for (int cc = 0; cc < 4; cc++) begin
      int t[4];
      t[0] = m[0][cc] + m[2][cc] + m[1][cc] + half_f(m[3][cc]);
      t[1] = m[0][cc] - m[2][cc] + half_f(m[1][cc]) - m[3][cc];
      t[2] = m[0][cc] - m[2][cc] - half_f(m[1][cc]) + m[3][cc];
      t[3] = m[0][cc] + m[2][cc] - m[1][cc] - half_f(m[3][cc]);
      for (int r = 0; r < 4; r++) begin
        int v;
        v = int'(p[8*(4*r+cc) +: 8]) + floordiv(t[r] + 32, 64);
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        res[8*(4*r+cc) +: 8] = 8'(v);
      end
    end
    return res;
  endfunction

  function automatic logic [255:0] rand_coef(int mode);
    logic [255:0] c;
    for (int k = 0; k < 16; k++) begin
      int v;
      case (mode)
        0: v = int'($signed(16'($urandom)));
        1: v = int'($urandom % 601) - 300;
        default: v = (($urandom % 4) == 0) ? int'($signed(16'($urandom))) : 0;
      endcase
      c[16*k +: 16] = 16'(v);
    end
    return c;
  endfunction

  function automatic logic [127:0] rand_pred();
    logic [127:0] p;
    for (int k = 0; k < 4; k++) p[32*k +: 32] = $urandom;
    return p;
  endfunction

  function automatic logic [255:0] fill(int v);
    logic [255:0] c;
    for (int k = 0; k < 16; k++) c[16*k +: 16] = 16'(v);
    return c;
  endfunction

  function automatic logic [127:0] flat_pred(int v);
    logic [127:0] p;
    for (int k = 0; k < 16; k++) p[8*k +: 8] = 8'(v);
    return p;
  endfunction

  // driver: offer one block, push its expected pixels when taken
  task automatic send(logic [255:0] c, logic [127:0] p, string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_coef  = c;
    in_pred  = p;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    it.pix   = model(c, p);
    it.cyc   = cyc;
    it.timed = !stall_mode;
    it.tag   = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_coef  = '0;
  endtask

  // monitor: compare at the falling edge, before the transfer edge
  bit           held = 1'b0;
  logic [127:0] held_pix;
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      if (held) begin
        checks++;
        if (!out_valid || out_pix !== held_pix) begin
          errors++;
          $display("FAIL R8 held output changed: valid=%0b pix=%h expected %h", out_valid, out_pix, held_pix);
        end
      end
      held = out_valid && !out_ready;
      held_pix = out_pix;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R9 unexpected output block: pix=%h expected none", out_pix);
        end else begin
          item_t it;
          it = q.pop_front();
          checks++;
          if (out_pix !== it.pix) begin
            errors++;
            $display("FAIL %s pixels: actual %h expected %h", it.tag, out_pix, it.pix);
          end
          if (it.timed) begin
            checks++;
            if (cyc - it.cyc != LAT) begin
              errors++;
              $display("FAIL R9 latency: actual %0d expected %0d", cyc - it.cyc, LAT);
            end
          end
        end
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    done = 1'b1;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 reset: out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: a single coefficient at row 1 col 0 versus row 0 col 1
    send(256'(512) << 16, flat_pred(128), "R1");
    send(256'(512) << 64, flat_pred(128), "R1");
    send(256'(16'hFF00) << 112, rand_pred(), "R1");
    // R3: odd negatives through the half weights
    send(fill(-1), flat_pred(100), "R3");
    send(fill(-3), flat_pred(100), "R3");
    send(rand_coef(1) | 256'h0001_0001_0001_0001_0001_0001_0001_0001, rand_pred(), "R3");
    // R4: DC values on either side of the rounding edges
    send(256'(16'(-33)), flat_pred(60), "R4");
    send(256'(16'(-32)), flat_pred(60), "R4");
    send(256'(31), flat_pred(60), "R4");
    send(256'(32), flat_pred(60), "R4");
    send(256'(16'(-97)), flat_pred(60), "R4");
    // R5: clamping at both ends
    send(256'(32767), flat_pred(200), "R5");
    send(256'(16'h8000), flat_pred(50), "R5");
    send(256'(100), flat_pred(254), "R5");
    // R6: full-range extremes
    send(fill(32767), rand_pred(), "R6");
    send(fill(-32768), rand_pred(), "R6");
    send(256'h7FFF_8000_7FFF_8000_8000_7FFF_8000_7FFF_7FFF_8000_7FFF_8000_8000_7FFF_8000_7FFF, rand_pred(), "R6");
    // R7: a zero block after a large one returns the prediction
    send(fill(-32768), rand_pred(), "R7");
    idle();
    idle();
    send('0, flat_pred(77), "R7");
    send(fill(32767), rand_pred(), "R7");
    send('0, rand_pred(), "R7");

    // R2 with R9 timing: back-to-back random blocks
    for (int n = 0; n < 10000; n++) send(rand_coef(n % 3), rand_pred(), "R2");
    idle();
    repeat (6) @(negedge clk);

    // R8: random output stalls
    stall_mode = 1'b1;
    for (int n = 0; n < 2000; n++) begin
      send(rand_coef(n % 3), rand_pred(), "R8");
      if ((n % 7) == 0) idle();
    end
    idle();
    repeat (40) @(negedge clk);
    stall_mode = 1'b0;
    repeat (10) @(negedge clk);

    done = 1'b1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9 blocks left undelivered: actual %0d expected 0", q.size());
    end
    summary();
  end
endmodule